// File: doc/BRIEF.md
# Sample-Tick Timer and Interrupt Level Unit

This block serves a sound processor that runs on a per-sample tick. It holds three 8-bit up-counting timers, A, B and C. Each timer has its own 3-bit prescale field. Software loads a timer with a start byte. On every tick the timer climbs toward its end value and then stops. When a timer runs out, it sets a pending bit. The block also has an enable mask, a write-one-to-clear register for the pending bits, and three level-select registers. Together, the three level-select registers give each interrupt source a 3-bit level.

An arbiter drives one 3-bit level output. It picks the highest-priority active request: a not-empty flag from an external MIDI receive FIFO, then timer A, then timer B, then timer C. Access goes through a simple single-cycle register bus. Writes are registered. Reads are combinational.

Address map (word addresses): 0, 1 and 2 are the control registers for timers A, B and C. 3 is the enable mask. 4 is the pending register on read and the clear register on write. 5, 6 and 7 are the three level-select registers. They supply level bits 0, 1 and 2 in that order.

Top module: `sti_top`

## Requirements
- R1: After reset, the timer registers read 0x00FF (prescale 0, byte 0xFF, internal count 0xFFFF, idle). The pending register reads 0 and `irq_level` is 0.
- R2: A write to a timer register sets the internal 16-bit count to {wr_data[7:0], 8'h00} and the prescale p to wr_data[10:8]. Each tick then adds 1<<(8-p), so the visible byte goes up by one every 2^p ticks.
- R3: When an addition makes the count exceed 0xFF00, the count saturates at 0xFFFF and stays there. The pending bit is set at the same time: bit 6 for timer A, bit 7 for timer B, bit 8 for timer C. A count of exactly 0xFF00 is not yet expired.
- R4: A read of a timer register returns the prescale in bits 10:8 and the upper count byte in bits 7:0. The other bits read 0.
- R5: A write to address 4 clears each pending bit whose position holds a 1 in wr_data. Bits written as 0 keep their value.
- R6: During that same clear write, every timer whose count is at or above 0xFF00 sets its pending bit again. This happens whichever bits were written.
- R7: A source's level is {sel2[i], sel1[i], sel0[i]}. The source index i is 3 for MIDI and 6 for timer A. Index 7 serves both timer B and timer C.
- R8: The priority is fixed: MIDI not-empty, then timer A, then timer B, then timer C. A timer takes part only when both its pending bit and its enable bit (mask bits 6, 7, 8) are set.
- R9: When no request is active, the level is 0.
- R10: `irq_level` is a register. It changes only on a tick edge, and it then uses the pending state as updated by that same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per audio sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 16 | Combinational read data |
| midi_nonempty | input | 1 | MIDI receive FIFO holds data |
| irq_level | output | 3 | Level of the winning request, 0 when none |

## Verification
The bench uses the default widths: a 16-bit internal count, a 3-bit prescale and 8-bit level-select registers. With these widths the expiry threshold at 0xFF00 and the 0xFFFF saturation value are exactly those of the requirements. Prescale 0 takes a timer through the boundary at 0xFF00 one tick at a time. Prescale 2 shows the four-tick divide within a few cycles. A byte of 0xFF loaded with no tick places the count exactly on the re-raise threshold.

// File: rtl/sti_pkg.sv
// Package sti_pkg: shared constants for the sample-tick timer unit.
// Assumes a fixed set of three timers and a single MIDI source.
package sti_pkg;
    localparam int NUM_TMR  = 3;
    // word addresses of the register bus
    localparam logic [2:0] A_TMR0  = 3'd0;
    localparam logic [2:0] A_EN    = 3'd3;
    localparam logic [2:0] A_PEND  = 3'd4;
    localparam logic [2:0] A_SEL0  = 3'd5;
    // bit positions shared by pending, enable and level-select registers
    localparam int PEND_LSB  = 6;   // timer A; B and C follow
    localparam int SRC_MIDI  = 3;
    localparam int SRC_TA    = 6;
    localparam int SRC_TBC   = 7;
endpackage

// File: rtl/sti_timer.sv
// Module sti_timer: one prescaled up-counter.
// Holds a count twice the visible width. A load places the byte in the upper half.
// Each tick adds 1 << (HALF - pre). A count that passes the limit saturates at all ones.
// Assumes PRE_W bits never select a shift larger than HALF.
module sti_timer #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [CNT_W/2-1:0]   load_byte,
    input  logic [PRE_W-1:0]     load_pre,
    output logic [CNT_W-1:0]     cnt,
    output logic [PRE_W-1:0]     pre,
    output logic                 expire,
    output logic                 spent
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] LIMIT = {{HALF{1'b1}}, {HALF{1'b0}}};

    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W:0]   sum;
    logic             run;

    // next count candidate and expiry detection
    always_comb begin
        sum    = {1'b0, cnt_q} + ((CNT_W+1)'(1) << (HALF - int'(pre_q)));
        run    = (cnt_q <= LIMIT);
        expire = tick && run && !load && (sum > {1'b0, LIMIT});
    end

    // count and prescale state; a load wins over a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            pre_q <= '0;
        end else if (load) begin
            cnt_q <= {load_byte, {HALF{1'b0}}};
            pre_q <= load_pre;
        end else if (tick && run) begin
            cnt_q <= (sum > {1'b0, LIMIT}) ? '1 : sum[CNT_W-1:0];
        end
    end

    assign cnt   = cnt_q;
    assign pre   = pre_q;
    assign spent = (cnt_q >= LIMIT);
endmodule

// File: rtl/sti_irq_arb.sv
// Module sti_irq_arb: fixed-priority level picker.
// Builds each source's level bit by bit from three select words.
// Returns the level of the first active source: MIDI, then A, then B, then C.
module sti_irq_arb #(
    parameter int SEL_W = 8
) (
    input  logic                 midi,
    input  logic [2:0]           req,     // pending & enabled, A..C
    input  logic [2:0][SEL_W-1:0] sel,
    output logic [2:0]           level
);
    import sti_pkg::*;

    logic [2:0] lvl_midi, lvl_a, lvl_bc;

    // assemble per-source levels, one bit from each select word
    for (genvar b = 0; b < 3; b++) begin : g_lvl
        assign lvl_midi[b] = sel[b][SRC_MIDI];
        assign lvl_a[b]    = sel[b][SRC_TA];
        assign lvl_bc[b]   = sel[b][SRC_TBC];
    end

    // priority selection
    always_comb begin
        if (midi)                 level = lvl_midi;
        else if (req[0])          level = lvl_a;
        else if (req[1] || req[2]) level = lvl_bc;
        else                      level = 3'd0;
    end
endmodule

// File: rtl/sti_top.sv
// Module sti_top: three sample-tick timers with pending, enable, clear and
// level-select registers, and a registered interrupt level output.
// Assumes single-cycle register writes and a one-cycle tick pulse.
module sti_top #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 3,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              midi_nonempty,
    output logic [2:0]        irq_level
);
    import sti_pkg::*;

    localparam int HALF = CNT_W / 2;

    logic [NUM_TMR-1:0][CNT_W-1:0] tmr_cnt;
    logic [NUM_TMR-1:0][PRE_W-1:0] tmr_pre;
    logic [NUM_TMR-1:0]            tmr_exp;
    logic [NUM_TMR-1:0]            tmr_spent;
    logic [NUM_TMR-1:0]            pend_q, pend_d, tmr_en;
    logic [DATA_W-1:0]             en_q;
    logic [2:0][SEL_W-1:0]         sel_q;
    logic [2:0]                    level_d, level_q;
    logic                          clr_wr;

    // one timer per source
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        sti_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .load      (wr_en && (wr_addr == ADDR_W'(A_TMR0 + t))),
            .load_byte (wr_data[HALF-1:0]),
            .load_pre  (wr_data[HALF +: PRE_W]),
            .cnt       (tmr_cnt[t]),
            .pre       (tmr_pre[t]),
            .expire    (tmr_exp[t]),
            .spent     (tmr_spent[t])
        );
        assign tmr_en[t] = en_q[PEND_LSB + t];
    end

    // pending next state: clear, re-raise of spent timers, tick expiry
    always_comb begin
        clr_wr = wr_en && (wr_addr == ADDR_W'(A_PEND));
        pend_d = pend_q | tmr_exp;
        if (clr_wr)
            pend_d = (pend_q & ~wr_data[PEND_LSB +: NUM_TMR]) | tmr_spent | tmr_exp;
    end

    sti_irq_arb #(.SEL_W(SEL_W)) u_arb (
        .midi  (midi_nonempty),
        .req   (pend_d & tmr_en),
        .sel   (sel_q),
        .level (level_d)
    );

    // pending, enable, select and level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            en_q    <= '0;
            sel_q   <= '0;
            level_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_en && wr_addr == ADDR_W'(A_EN))
                en_q <= wr_data;
            for (int s = 0; s < 3; s++)
                if (wr_en && wr_addr == ADDR_W'(A_SEL0 + s))
                    sel_q[s] <= wr_data[SEL_W-1:0];
            if (tick)
                level_q <= level_d;
        end
    end

    // combinational read-back mux
    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NUM_TMR))
            rd_data = DATA_W'({tmr_pre[rd_addr], tmr_cnt[rd_addr][CNT_W-1:HALF]});
        else if (rd_addr == ADDR_W'(A_EN))
            rd_data = en_q;
        else if (rd_addr == ADDR_W'(A_PEND))
            rd_data = DATA_W'(pend_q) << PEND_LSB;
        else
            rd_data = DATA_W'(sel_q[rd_addr - ADDR_W'(A_SEL0)]);
    end

    assign irq_level = level_q;
endmodule

// File: rtl/sti_chk.sv
// Module sti_chk: temporal checks on the timer unit, bound into sti_top.
module sti_chk #(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic                  midi_nonempty,
    input logic [2:0]            irq_level,
    input logic [2:0][CNT_W-1:0] tmr_cnt,
    input logic [2:0]            pend_q,
    input logic [2:0][SEL_W-1:0] sel_q
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] LIMIT = {{HALF{1'b1}}, {HALF{1'b0}}};

    // R10
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(irq_level));

    // R8
    midi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && midi_nonempty && !wr_en |=> irq_level == {sel_q[2][3], sel_q[1][3], sel_q[0][3]});

    for (genvar t = 0; t < 3; t++) begin : g_t
        // R3
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_cnt[t] == '1 && !(wr_en && wr_addr == ADDR_W'(t)) |=> tmr_cnt[t] == '1);
        // R3
        pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[t] && !(wr_en && wr_addr == ADDR_W'(4)) |=> pend_q[t]);
        // R6
        rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_addr == ADDR_W'(4) && tmr_cnt[t] >= LIMIT |=> pend_q[t]);
    end
endmodule

bind sti_top sti_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .midi_nonempty (midi_nonempty),
    .irq_level     (irq_level),
    .tmr_cnt       (tmr_cnt),
    .pend_q        (pend_q),
    .sel_q         (sel_q)
);

// File: tb/sti_top_tb.sv
// Bench sti_top_tb: directed scenarios, one task each, self-checking.
module sti_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        midi_nonempty = 1'b0;
    logic [2:0]  irq_level;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    sti_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .midi_nonempty(midi_nonempty), .irq_level(irq_level)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        rd_addr = a;
        #1;
        check(req, int'(rd_data), exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 timer A", 3'd0, 16'h00FF);
        rd_chk("R1 timer B", 3'd1, 16'h00FF);
        rd_chk("R1 timer C", 3'd2, 16'h00FF);
        rd_chk("R1 pending", 3'd4, 0);
        check("R1 level", irq_level, 0);
    endtask

    task automatic t_count;
        wr(3'd0, 16'h00FD);
        rd_chk("R2 load", 3'd0, 16'h00FD);
        pulse(1); rd_chk("R2 step p0", 3'd0, 16'h00FE);
        pulse(1); rd_chk("R3 at FF00 byte", 3'd0, 16'h00FF);
        rd_chk("R3 FF00 not expired", 3'd4, 0);
        pulse(1); rd_chk("R3 saturate", 3'd0, 16'h00FF);
        rd_chk("R3 pend A bit6", 3'd4, 16'h0040);
        pulse(2); rd_chk("R3 stays", 3'd0, 16'h00FF);
    endtask

    task automatic t_prescale;
        wr(3'd1, 16'h0210);
        pulse(3);
        rd_chk("R4 prescale kept", 3'd1, 16'h0210);
        pulse(1);
        rd_chk("R2 p2 four ticks", 3'd1, 16'h0211);
    endtask

    task automatic t_clear;
        wr(3'd4, 16'h0040);
        rd_chk("R6 re-raise A and C", 3'd4, 16'h0140);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0000);
        rd_chk("R5 zero write keeps", 3'd4, 16'h0140);
        wr(3'd4, 16'h01C0);
        rd_chk("R5 A cleared C re-raised", 3'd4, 16'h0100);
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'h0100);
        rd_chk("R5 all clear", 3'd4, 0);
        wr(3'd2, 16'h00FF);
        wr(3'd4, 16'h0100);
        rd_chk("R6 exact FF00 re-raise", 3'd4, 16'h0100);
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'h0100);
        rd_chk("R5 C cleared", 3'd4, 0);
    endtask

    task automatic t_level;
        wr(3'd5, 16'h0040);
        wr(3'd6, 16'h0080);
        wr(3'd7, 16'h0008);
        @(negedge clk); midi_nonempty = 1'b1;
        @(negedge clk);
        check("R10 no tick no change", irq_level, 0);
        pulse(1); check("R7 midi level", irq_level, 4);
        @(negedge clk); midi_nonempty = 1'b0;
        wr(3'd0, 16'h00FF);
        pulse(1); check("R8 A pending masked", irq_level, 0);
        wr(3'd3, 16'h0040);
        check("R10 enable waits tick", irq_level, 0);
        pulse(1); check("R7 A level", irq_level, 1);
        @(negedge clk); midi_nonempty = 1'b1;
        pulse(1); check("R8 midi over A", irq_level, 4);
        @(negedge clk); midi_nonempty = 1'b0;
        wr(3'd3, 16'h01C0);
        wr(3'd2, 16'h00FF);
        pulse(1); check("R8 A over C", irq_level, 1);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0040);
        pulse(1); check("R7 C shares B level", irq_level, 2);
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'h01C0);
        pulse(1); check("R9 idle level", irq_level, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_count;
        t_prescale;
        t_clear;
        t_level;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule